// File: doc/BRIEF.md
# Interval Router with Adaptive Link Bundles

This block makes the routing decision for each packet header that arrives at one input of a packet switch. The destination number carried in the header is compared at once against a table of sixteen ascending lower bounds. Each bound opens a contiguous range of destinations that runs up to the next bound. The range that holds the destination picks a table entry. The entry names a bundle of equivalent output links. Among the links of that bundle that are not busy, the lowest-numbered one is taken. Because of this, a packet never waits for one link while a twin link in the same bundle is idle.

Each output link has a strip flag. When the flag is set, the switch core discards the current header as the packet leaves on that link, and the header that follows becomes the one that routes the packet at the next stage. Taken together, strip flags and range assignment allow hierarchical networks and two-phase randomized routing, with one range of destinations set aside for the random phase and another for the final phase. For the random phase the block also offers a pseudo-random intermediate destination. This value comes from a 16-bit LFSR and is reduced modulo a configurable range, so that an ingress stage can prepend it as an extra header.

A single configuration port writes the bounds, the bundle masks, the strip flags and the random range. When every link of a bundle is busy, the request stays pending and is checked again in every cycle until one of those links frees.

Top module: `irouter_top`

## Requirements
- R1: After reset, req_ready is 1 and route_valid is 0. All bounds, bundle masks, strip flags and the random range are 0. rand_dest equals the low byte of the LFSR seed 16'hACE1, which is 8'hE1.
- R2: The entry reported on route_entry is the highest index i whose bound is less than or equal to the pending destination. Entry 0 is reported when no bound qualifies.
- R3: A destination equal to bound[i] selects entry i when bound[i+1] is larger. A destination of bound[i]-1 selects entry i-1.
- R4: route_port is the lowest-numbered link that is set in the selected entry's bundle mask and whose link_busy bit was 0 at the deciding edge.
- R5: While every link in the bundle is busy, route_valid stays 0 and req_ready stays 0. The route appears on the clock edge that follows the first cycle in which a bundle link is free.
- R6: route_strip equals the strip flag of the chosen link.
- R7: A request accepted at one edge, with a free bundle link in the next cycle, produces a route_valid pulse at the following edge. The pulse lasts exactly one cycle.
- R8: The LFSR shifts left by one bit on each cycle in which rand_take is high. The new bit 0 is s[15]^s[13]^s[12]^s[10]. rand_dest is the LFSR state modulo the configured range, and a range of 0 means 256. rand_dest changes only on a rand_take or on a range write.
- R9: A configuration write takes effect for the next request that is decided. A request offered while another one is pending is not accepted and produces no route. cfg_kind encodes the target: 0 writes bound[cfg_idx], 1 writes mask[cfg_idx], 2 writes all strip flags, and 3 writes the random range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target of the write: bound, mask, strip flags, range |
| cfg_idx | input | 4 | Table entry written |
| cfg_data | input | 8 | Write data |
| req_valid | input | 1 | A header destination is offered |
| req_dest | input | 8 | Destination number from the header |
| req_ready | output | 1 | No request pending; an offer is taken |
| link_busy | input | 8 | One bit per output link, 1 means occupied |
| route_valid | output | 1 | One-cycle pulse with a routing result |
| route_port | output | 3 | Chosen output link |
| route_entry | output | 4 | Table entry that matched |
| route_strip | output | 1 | Discard the header on the chosen link |
| rand_take | input | 1 | Advance the random generator |
| rand_dest | output | 8 | Random intermediate destination |

## Verification
The situation that is hardest to reach from the ports is a request that sits pending while more offers arrive and the busy pattern stays full. The result must leave on the one link freed later, and the extra offers must leave no trace. The stimulus holds every link busy, drives a second destination for several cycles, and then frees only the highest link of the bundle. The scoreboard then expects exactly one route, on that link. Boundary selection is covered by sweeping all 256 destinations against a bound table with uneven gaps, and by alternating busy patterns that sometimes mask the preferred link.

// File: rtl/irt_pkg.sv
// Shared definitions for the interval router.
// Assumes: the LFSR width is fixed at 16 bits.
package irt_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        CFG_BOUND = 2'd0,
        CFG_MASK  = 2'd1,
        CFG_STRIP = 2'd2,
        CFG_RANGE = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/irt_lookup.sv
// Parallel interval lookup: reports the highest entry whose lower bound
// does not exceed the destination.
// Assumes: bounds are packed entry 0 in the low bits; ascending order is
// expected but not required for a defined result.
module irt_lookup #(
    parameter int DEST_W  = 8,
    parameter int N_ENTRY = 16
) (
    input  logic [DEST_W-1:0]         dest,
    input  logic [N_ENTRY*DEST_W-1:0] bounds,
    output logic [$clog2(N_ENTRY)-1:0] entry
);
    localparam int ENT_W = $clog2(N_ENTRY);

    logic [N_ENTRY-1:0] at_or_above;

    // One comparator per entry, all working side by side.
    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign at_or_above[g] = dest >= bounds[g*DEST_W +: DEST_W];
    end

    // Keep the highest entry whose bound qualifies.
    always_comb begin
        entry = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (at_or_above[i]) entry = ENT_W'(i);
        end
    end
endmodule

// File: rtl/irt_pick.sv
// Adaptive choice inside a bundle: lowest-numbered link that is in the
// mask and not busy.
// Assumes: busy bits are already synchronous to clk.
module irt_pick #(
    parameter int N_OUT = 8
) (
    input  logic [N_OUT-1:0]         mask,
    input  logic [N_OUT-1:0]         busy,
    output logic                     any,
    output logic [$clog2(N_OUT)-1:0] port
);
    localparam int PORT_W = $clog2(N_OUT);

    logic [N_OUT-1:0] cand;

    assign cand = mask & ~busy;
    assign any  = |cand;

    // Scan downward so the lowest free link wins.
    always_comb begin
        port = '0;
        for (int i = N_OUT - 1; i >= 0; i--) begin
            if (cand[i]) port = PORT_W'(i);
        end
    end
endmodule

// File: rtl/irt_lfsr.sv
// 16-bit Fibonacci LFSR, taps 15/13/12/10, shifts left on step.
// Assumes: synchronous active-low reset loads the seed.
module irt_lfsr
    import irt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);
    // Advance one position per requested step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= LFSR_SEED;
        else if (step)
            state <= {state[LFSR_W-2:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
    end
endmodule

// File: rtl/irt_checker.sv
// Temporal checks on the interval router ports, bound to irouter_top.
module irt_checker #(
    parameter int DEST_W = 8,
    parameter int N_OUT  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [N_OUT-1:0]         link_busy,
    input logic                     route_valid,
    input logic [$clog2(N_OUT)-1:0] route_port,
    input logic                     rand_take,
    input logic                     cfg_we,
    input logic [1:0]               cfg_kind,
    input logic [DEST_W-1:0]        rand_dest
);
    logic [N_OUT-1:0] busy_seen;

    // Capture the busy pattern seen at each deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_seen <= '0;
        else        busy_seen <= link_busy;
    end

    // R7: a route is a single-cycle pulse
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |=> !route_valid);

    // R7: an accepted request blocks further offers in the next cycle
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: once a route is issued, the request slot is free again
    p_free_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> req_ready);

    // R4: the chosen link was not busy when chosen
    p_idle_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> !busy_seen[route_port]);

    // R8: random value holds without a take or a range write
    p_rand_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rand_take && !(cfg_we && cfg_kind == 2'd3)) |=> $stable(rand_dest));
endmodule

bind irouter_top irt_checker #(.DEST_W(DEST_W), .N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .link_busy(link_busy), .route_valid(route_valid), .route_port(route_port),
    .rand_take(rand_take), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .rand_dest(rand_dest)
);

// File: rtl/irouter_top.sv
// Interval router top: holds the route table, keeps one pending header,
// and issues a registered route when a bundle link is free.
// Assumes: link_busy is synchronous; the switch core consumes route_valid
// pulses without back-pressure.
module irouter_top
    import irt_pkg::*;
#(
    parameter int DEST_W  = 8,
    parameter int N_ENTRY = 16,
    parameter int N_OUT   = 8,
    parameter int CFG_W   = (DEST_W > N_OUT) ? DEST_W : N_OUT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_kind,
    input  logic [$clog2(N_ENTRY)-1:0] cfg_idx,
    input  logic [CFG_W-1:0]           cfg_data,
    input  logic                       req_valid,
    input  logic [DEST_W-1:0]          req_dest,
    output logic                       req_ready,
    input  logic [N_OUT-1:0]           link_busy,
    output logic                       route_valid,
    output logic [$clog2(N_OUT)-1:0]   route_port,
    output logic [$clog2(N_ENTRY)-1:0] route_entry,
    output logic                       route_strip,
    input  logic                       rand_take,
    output logic [DEST_W-1:0]          rand_dest
);
    localparam int ENT_W  = $clog2(N_ENTRY);
    localparam int PORT_W = $clog2(N_OUT);

    logic [DEST_W-1:0]         bound_q [N_ENTRY];
    logic [N_OUT-1:0]          mask_q  [N_ENTRY];
    logic [N_OUT-1:0]          strip_q;
    logic [DEST_W-1:0]         range_q;
    logic [N_ENTRY*DEST_W-1:0] bound_flat;
    logic                      pend_q;
    logic [DEST_W-1:0]         dest_q;
    logic [ENT_W-1:0]          ent_sel;
    logic [N_OUT-1:0]          mask_sel;
    logic                      have_free;
    logic [PORT_W-1:0]         free_port;
    logic [LFSR_W-1:0]         lfsr_s;
    logic [LFSR_W-1:0]         reduced;

    // Table writes from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) begin
                bound_q[i] <= '0;
                mask_q[i]  <= '0;
            end
            strip_q <= '0;
            range_q <= '0;
        end else if (cfg_we) begin
            case (cfg_kind_e'(cfg_kind))
                CFG_BOUND: bound_q[cfg_idx] <= cfg_data[DEST_W-1:0];
                CFG_MASK:  mask_q[cfg_idx]  <= cfg_data[N_OUT-1:0];
                CFG_STRIP: strip_q          <= cfg_data[N_OUT-1:0];
                default:   range_q          <= cfg_data[DEST_W-1:0];
            endcase
        end
    end

    // Pack the bounds for the parallel comparator.
    always_comb begin
        for (int i = 0; i < N_ENTRY; i++)
            bound_flat[i*DEST_W +: DEST_W] = bound_q[i];
    end

    irt_lookup #(.DEST_W(DEST_W), .N_ENTRY(N_ENTRY)) u_lookup (
        .dest(dest_q), .bounds(bound_flat), .entry(ent_sel)
    );

    assign mask_sel = mask_q[ent_sel];

    irt_pick #(.N_OUT(N_OUT)) u_pick (
        .mask(mask_sel), .busy(link_busy), .any(have_free), .port(free_port)
    );

    assign req_ready = !pend_q;

    // Accept a header, then retry the decision each cycle until a link frees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            dest_q      <= '0;
            route_valid <= 1'b0;
            route_port  <= '0;
            route_entry <= '0;
            route_strip <= 1'b0;
        end else begin
            route_valid <= 1'b0;
            if (pend_q) begin
                if (have_free) begin
                    pend_q      <= 1'b0;
                    route_valid <= 1'b1;
                    route_port  <= free_port;
                    route_entry <= ent_sel;
                    route_strip <= strip_q[free_port];
                end
            end else if (req_valid) begin
                pend_q <= 1'b1;
                dest_q <= req_dest;
            end
        end
    end

    irt_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .step(rand_take), .state(lfsr_s));

    // Reduce the LFSR state into the configured destination range.
    always_comb begin
        if (range_q == '0) reduced = LFSR_W'(lfsr_s[DEST_W-1:0]);
        else               reduced = lfsr_s % LFSR_W'(range_q);
    end

    assign rand_dest = reduced[DEST_W-1:0];
endmodule

// File: tb/irouter_top_tb.sv
// Scoreboard bench: the driver pushes expected routes, the monitor pops them.
module irouter_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_kind = '0;
    logic [3:0] cfg_idx = '0;
    logic [7:0] cfg_data = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_dest = '0;
    logic       req_ready;
    logic [7:0] link_busy = '0;
    logic       route_valid;
    logic [2:0] route_port;
    logic [3:0] route_entry;
    logic       route_strip;
    logic       rand_take = 1'b0;
    logic [7:0] rand_dest;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] sb_q[$];
    string      tag_q[$];
    logic [7:0] bnd [16];
    logic [7:0] msk [16];
    logic [7:0] strip_v;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    irouter_top u_dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int kind, input int idx, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_idx = 4'(idx); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int ref_entry(input int d);
        int e = 0;
        for (int i = 0; i < 16; i++) if (d >= bnd[i]) e = i;
        return e;
    endfunction

    function automatic int low_bit(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int high_bit(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) return i;
        return 0;
    endfunction

    // Driver: offer one header with a busy pattern and push the expected route.
    task automatic send(input int d, input logic [7:0] busy, input string tag);
        int e, p;
        logic [7:0] fr;
        e  = ref_entry(d);
        fr = msk[e] & ~busy;
        p  = low_bit(fr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        link_busy = busy; req_valid = 1'b1; req_dest = 8'(d);
        if (fr != 0) begin
            sb_q.push_back({4'(e), 3'(p), strip_v[p]});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare every issued route against the queue head.
    always @(negedge clk) begin
        if (rst_n && route_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected route", int'(route_entry), -1);
            end else begin
                logic [7:0] ex;
                string tg;
                ex = sb_q.pop_front();
                tg = tag_q.pop_front();
                check(route_entry == ex[7:4], {tg, " entry"}, int'(route_entry), int'(ex[7:4]));
                check(route_port == ex[3:1], "R4 port", int'(route_port), int'(ex[3:1]));
                check(route_strip == ex[0], "R6 strip", int'(route_strip), int'(ex[0]));
            end
        end
    end

    function automatic logic [7:0] rand_ref(input logic [15:0] s, input int r);
        if (r == 0) return s[7:0];
        return 8'(s % 16'(r));
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int d, e;
        logic [7:0] busy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(route_valid == 1'b0, "R1 route_valid", int'(route_valid), 0);
        check(rand_dest == 8'hE1, "R1 rand_dest", int'(rand_dest), 225);

        // Table with uneven gaps; two-link bundles; strip flags.
        for (int i = 0; i < 16; i++) begin
            bnd[i] = 8'(i * 15 + (i % 3));
            msk[i] = 8'((1 << (i % 8)) | (1 << ((i + 3) % 8)));
            cfg(0, i, bnd[i]);
            cfg(1, i, msk[i]);
        end
        strip_v = 8'b1010_0101;
        cfg(2, 0, strip_v);

        // R2 / R3 sweep of every destination; odd ones mask the preferred link (R4).
        for (int dd = 0; dd < 256; dd++) begin
            string tg;
            e = ref_entry(dd);
            tg = "R2";
            for (int i = 1; i < 16; i++)
                if (dd == bnd[i] || dd == bnd[i] - 1) tg = "R3";
            busy = (dd % 2 == 1) ? 8'(1 << low_bit(msk[e])) : 8'h00;
            send(dd, busy, tg);
        end
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7 all routes issued", sb_q.size(), 0);

        // R5 / R9: every link busy; extra offers while pending.
        d = 50;
        e = ref_entry(d);
        send(d, 8'hFF, "R5");
        repeat (4) begin
            @(negedge clk);
            check(route_valid == 1'b0, "R5 no route while blocked", int'(route_valid), 0);
            check(req_ready == 1'b0, "R5 ready low while pending", int'(req_ready), 0);
        end
        req_valid = 1'b1; req_dest = 8'd200;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        busy = ~8'(1 << high_bit(msk[e]));
        sb_q.push_back({4'(e), 3'(high_bit(msk[e])), strip_v[high_bit(msk[e])]});
        tag_q.push_back("R5");
        link_busy = busy;
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R5 route after link frees", sb_q.size(), 0);
        check(req_ready == 1'b1, "R9 offer during pending dropped", int'(req_ready), 1);

        // R9: reconfigured bound applies to the next decision.
        bnd[15] = 8'd200;
        cfg(0, 15, 200);
        send(210, 8'h00, "R9");
        send(199, 8'h00, "R9");
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R9 reconfig routes", sb_q.size(), 0);

        // R8 random destination generator.
        cfg(3, 0, 100);
        check(rand_dest == rand_ref(lf, 100), "R8 range 100", int'(rand_dest), int'(rand_ref(lf, 100)));
        for (int k = 0; k < 20; k++) begin
            rand_take = 1'b1;
            @(negedge clk);
            rand_take = 1'b0;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            check(rand_dest == rand_ref(lf, 100), "R8 step", int'(rand_dest), int'(rand_ref(lf, 100)));
            @(negedge clk);
            check(rand_dest == rand_ref(lf, 100), "R8 hold", int'(rand_dest), int'(rand_ref(lf, 100)));
        end
        cfg(3, 0, 0);
        check(rand_dest == rand_ref(lf, 0), "R8 range 256", int'(rand_dest), int'(rand_ref(lf, 0)));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule